// File: doc/BRIEF.md
# Host Port Register Interface with DMA Transfer Modes

This block is the host-facing register window of a parallel host-to-processor port. A host reaches a control register, a status register and three byte addresses that together form one 24-bit data word. Words written by the host are passed to the processor side. Words loaded by the processor are read back by the host. Byte-lane order at the three data addresses is either big- or little-endian.

The control register holds a request-enable bit for each direction and a general-purpose flag that only the host can change. The flag is mirrored to the processor side. Bits 6:5 are shared. A 3-bit processor-side mode field decides whether bit 5 selects the endian order or whether bits 6:5 together select the transfer mode. The transfer mode is either interrupt-driven or DMA with an 8-, 16- or 24-bit word. In interrupt mode the request output is a plain "data ready" interrupt. In DMA mode that output requests one byte transfer per acknowledged cycle. The acknowledge input then moves bytes through the word, starting at the least significant byte.

Top module: `hpi_host_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 2) reads 0x02 (bit 1 transmit-empty = 1, bit 0 receive-full = 0), `host_req` is 0 and `hf_status` is 0.
- R2: Control bit 0 (receive request enable), bit 1 (transmit request enable) and bit 4 (flag) are written by a host write to address 0 and read back there. Bits 2, 3 and 7 read 0. `hf_status` follows bit 4 and changes only on a host write to address 0.
- R3: Bit 5 is stored and read back only when `p_mode` is 000 or 100, and bit 6 only when `p_mode` is 100. In every other mode, writes to these bits are ignored and they read 0.
- R4: Big-endian order (bit 5 clear, or `p_mode` not 000): address 5 holds bits 23:16, address 6 bits 15:8 and address 7 bits 7:0 of the data word.
- R5: Little-endian order applies only when `p_mode` is 000 and bit 5 is set: address 5 holds bits 7:0, address 6 bits 15:8 and address 7 bits 23:16.
- R6: A host write to address 7 completes a host-to-processor word: `p_h2p_valid` rises and `p_h2p_data` carries the word. A host read of address 7 empties the receive word: `p_p2h_ready` rises.
- R7: Interrupt mode (`p_mode` not 100, or bits 6:5 = 00): `host_req` = (bit 0 AND receive-full) OR (bit 1 AND transmit-empty). `h_ack` neither moves data nor changes any flag.
- R8: DMA mode (`p_mode` = 100 with bits 6:5 = 01, 10 or 11 for 24-, 16- or 8-bit words): bit 1 alone selects host-to-processor and bit 0 alone selects processor-to-host. `host_req` is high only while that direction is ready (transmit-empty or receive-full). With both bits set or both clear, `host_req` stays 0.
- R9: DMA host-to-processor: each cycle with `h_ack` and `host_req` high writes `h_wdata` into the next byte lane, starting at lane 0 (bits 7:0). Bytes above the word size become 0. After the last lane the word completes as in R6 and `host_req` drops.
- R10: DMA processor-to-host: while `h_ack` and `host_req` are high, `h_rdata` carries the current lane byte, starting at lane 0. The lane advances each such cycle. After the last lane the receive word is emptied as in R6.
- R11: `p_h2p_valid` stays high until `p_h2p_take`, which sets transmit-empty again. `p_p2h_load` captures `p_p2h_data` and clears `p_p2h_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_addr | input | ADDR_W | Host register address |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | BYTE_W | Host write data |
| h_rdata | output | BYTE_W | Host read data (combinational) |
| h_ack | input | 1 | Host acknowledge (DMA byte transfer) |
| host_req | output | 1 | Interrupt or DMA request to the host |
| p_mode | input | 3 | Processor-side mode field |
| hf_status | output | 1 | Mirror of the host flag |
| p_h2p_data | output | 3*BYTE_W | Word from host to processor |
| p_h2p_valid | output | 1 | Host-to-processor word pending |
| p_h2p_take | input | 1 | Processor consumes the pending word |
| p_p2h_data | input | 3*BYTE_W | Word from processor to host |
| p_p2h_load | input | 1 | Processor loads `p_p2h_data` |
| p_p2h_ready | output | 1 | Receive word empty, processor may load |

## Verification
Most faults in this block sit in a small amount of state: the stored bits 6:5, the lane counter and the two data-ready flags. An error in any of them reaches the ports within one or two cycles.

- A wrong mode interpretation shows on the next control-register read, or on the next acknowledged transfer as a byte in the wrong lane.
- A lane counter that fails to advance or to wrap shows in `h_rdata` during the acknowledge cycle itself. It also shows as a wrong `p_h2p_data` in the cycle after the last byte.
- A stale ready flag shows at once as a wrong level on `host_req`, and on the status register at the next read.

// File: rtl/hpi_pkg.sv
`timescale 1ns/1ps
package hpi_pkg;

   // Transfer mode held in control bits 6:5 (only meaningful when p_mode == 100)
   typedef enum logic [1:0] {
      XM_IRQ   = 2'b00,
      XM_DMA24 = 2'b01,
      XM_DMA16 = 2'b10,
      XM_DMA8  = 2'b11
   } xfer_mode_e;

   localparam int          LANES         = 3;
   localparam logic [2:0]  PMODE_ENDIAN  = 3'b000;
   localparam logic [2:0]  PMODE_DMA     = 3'b100;

   // Control register bit positions
   localparam int CB_RREQ = 0;
   localparam int CB_TREQ = 1;
   localparam int CB_FLAG = 4;
   localparam int CB_SH0  = 5;
   localparam int CB_SH1  = 6;

   // Index of the final byte lane of a DMA word
   function automatic logic [1:0] last_lane(xfer_mode_e m);
      case (m)
         XM_DMA24: last_lane = 2'd2;
         XM_DMA16: last_lane = 2'd1;
         default:  last_lane = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/hpi_ctrl_reg.sv
`timescale 1ns/1ps
module hpi_ctrl_reg
   import hpi_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wbits,      // {bit6, bit5, flag, treq, rreq}
   input  logic [2:0]        p_mode,
   output logic [BYTE_W-1:0] rd_val,
   output logic              rreq_en,
   output logic              treq_en,
   output logic              flag,
   output logic              little_end,
   output logic              dma_on,
   output xfer_mode_e        xmode
);

   logic sh0_q, sh1_q;
   logic mode_endian, mode_dma;

   assign mode_endian = (p_mode == PMODE_ENDIAN);
   assign mode_dma    = (p_mode == PMODE_DMA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rreq_en <= 1'b0;
         treq_en <= 1'b0;
         flag    <= 1'b0;
         sh0_q   <= 1'b0;
         sh1_q   <= 1'b0;
      end else if (wr_en) begin
         rreq_en <= wbits[0];
         treq_en <= wbits[1];
         flag    <= wbits[2];
         if (mode_endian || mode_dma) sh0_q <= wbits[3];
         if (mode_dma)                sh1_q <= wbits[4];
      end
   end

   always_comb begin
      rd_val          = '0;
      rd_val[CB_RREQ] = rreq_en;
      rd_val[CB_TREQ] = treq_en;
      rd_val[CB_FLAG] = flag;
      rd_val[CB_SH0]  = (mode_endian || mode_dma) & sh0_q;
      rd_val[CB_SH1]  = mode_dma & sh1_q;
   end

   assign little_end = mode_endian & sh0_q;
   assign xmode      = mode_dma ? xfer_mode_e'({sh1_q, sh0_q}) : XM_IRQ;
   assign dma_on     = (xmode != XM_IRQ);

endmodule

// File: rtl/hpi_dma_seq.sv
`timescale 1ns/1ps
module hpi_dma_seq
   import hpi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  xfer_mode_e xmode,
   input  logic       dma_on,
   input  logic       rreq_en,
   input  logic       treq_en,
   input  logic       txe,
   input  logic       rxf,
   input  logic       ack,
   output logic       host_req,
   output logic       dir_h2p,
   output logic       dir_p2h,
   output logic [1:0] lane,
   output logic       xfer,
   output logic       word_done
);

   logic irq_req;

   assign dir_h2p   = dma_on & treq_en & ~rreq_en;
   assign dir_p2h   = dma_on & rreq_en & ~treq_en;
   assign irq_req   = (rreq_en & rxf) | (treq_en & txe);
   assign host_req  = dma_on ? ((dir_h2p & txe) | (dir_p2h & rxf)) : irq_req;
   assign xfer      = dma_on & ack & host_req;
   assign word_done = xfer & (lane == last_lane(xmode));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane <= 2'd0;
      else if (!dma_on)   lane <= 2'd0;
      else if (word_done) lane <= 2'd0;
      else if (xfer)      lane <= lane + 2'd1;
   end

endmodule

// File: rtl/hpi_data_regs.sv
`timescale 1ns/1ps
module hpi_data_regs
   import hpi_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             tx_we,
   input  logic                         tx_clr_upper,
   input  logic [BYTE_W-1:0]            wbyte,
   input  logic                         h2p_done,
   input  logic                         p_take,
   input  logic                         p_load,
   input  logic [LANES-1:0][BYTE_W-1:0] p_load_word,
   input  logic                         p2h_done,
   output logic [LANES-1:0][BYTE_W-1:0] tx_word,
   output logic [LANES-1:0][BYTE_W-1:0] rx_word,
   output logic                         txe,
   output logic                         rxf
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       tx_word[i] <= '0;
         else if (tx_we[i])                tx_word[i] <= wbyte;
         else if (tx_clr_upper && (i > 0)) tx_word[i] <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_word <= '0;
      else if (p_load) rx_word <= p_load_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        txe <= 1'b1;
      else if (h2p_done) txe <= 1'b0;
      else if (p_take)   txe <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rxf <= 1'b0;
      else if (p_load)   rxf <= 1'b1;
      else if (p2h_done) rxf <= 1'b0;
   end

endmodule

// File: rtl/hpi_host_port.sv
`timescale 1ns/1ps
module hpi_host_port
   import hpi_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int ICR_ADDR  = 0,
   parameter int STAT_ADDR = 2,
   parameter int DATA_BASE = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       h_addr,
   input  logic                    h_wr,
   input  logic                    h_rd,
   input  logic [BYTE_W-1:0]       h_wdata,
   output logic [BYTE_W-1:0]       h_rdata,
   input  logic                    h_ack,
   output logic                    host_req,
   input  logic [2:0]              p_mode,
   output logic                    hf_status,
   output logic [LANES*BYTE_W-1:0] p_h2p_data,
   output logic                    p_h2p_valid,
   input  logic                    p_h2p_take,
   input  logic [LANES*BYTE_W-1:0] p_p2h_data,
   input  logic                    p_p2h_load,
   output logic                    p_p2h_ready
);

   localparam logic [ADDR_W-1:0] A_ICR   = ADDR_W'(ICR_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(DATA_BASE);
   localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(DATA_BASE + LANES - 1);

   if (BYTE_W < 7)
      $error("BYTE_W must hold control bits 6:0");
   if (DATA_BASE + LANES > (1 << ADDR_W))
      $error("data window exceeds address range");
   if (ICR_ADDR == STAT_ADDR || (ICR_ADDR >= DATA_BASE && ICR_ADDR < DATA_BASE + LANES)
       || (STAT_ADDR >= DATA_BASE && STAT_ADDR < DATA_BASE + LANES))
      $error("register addresses overlap");

   logic [BYTE_W-1:0] icr_rd;
   logic rreq_en, treq_en, little_end, dma_on;
   xfer_mode_e xmode;
   logic dir_h2p, dir_p2h, xfer, word_done, txe, rxf;
   logic [1:0] lane, off, host_lane;
   logic data_hit;
   logic [LANES-1:0] tx_we;
   logic [LANES-1:0][BYTE_W-1:0] tx_word, rx_word;

   hpi_ctrl_reg #(.BYTE_W(BYTE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(h_wr && h_addr == A_ICR),
      .wbits({h_wdata[CB_SH1], h_wdata[CB_SH0], h_wdata[CB_FLAG],
              h_wdata[CB_TREQ], h_wdata[CB_RREQ]}),
      .p_mode(p_mode), .rd_val(icr_rd),
      .rreq_en(rreq_en), .treq_en(treq_en), .flag(hf_status),
      .little_end(little_end), .dma_on(dma_on), .xmode(xmode)
   );

   hpi_dma_seq u_seq (
      .clk(clk), .rst_n(rst_n), .xmode(xmode), .dma_on(dma_on),
      .rreq_en(rreq_en), .treq_en(treq_en), .txe(txe), .rxf(rxf),
      .ack(h_ack), .host_req(host_req), .dir_h2p(dir_h2p), .dir_p2h(dir_p2h),
      .lane(lane), .xfer(xfer), .word_done(word_done)
   );

   // Address to byte-lane mapping
   assign data_hit  = (h_addr >= A_FIRST) && (h_addr <= A_LAST);
   assign off       = 2'(h_addr - A_FIRST);
   assign host_lane = little_end ? off : (2'(LANES - 1) - off);

   for (genvar i = 0; i < LANES; i++) begin : g_we
      assign tx_we[i] = (h_wr && data_hit && host_lane == 2'(i))
                      | (xfer && dir_h2p && lane == 2'(i));
   end

   hpi_data_regs #(.BYTE_W(BYTE_W)) u_data (
      .clk(clk), .rst_n(rst_n),
      .tx_we(tx_we),
      .tx_clr_upper(xfer && dir_h2p && lane == 2'd0),
      .wbyte(h_wdata),
      .h2p_done((h_wr && h_addr == A_LAST) || (word_done && dir_h2p)),
      .p_take(p_h2p_take),
      .p_load(p_p2h_load), .p_load_word(p_p2h_data),
      .p2h_done((h_rd && h_addr == A_LAST) || (word_done && dir_p2h)),
      .tx_word(tx_word), .rx_word(rx_word), .txe(txe), .rxf(rxf)
   );

   always_comb begin
      h_rdata = '0;
      if (xfer && dir_p2h)       h_rdata = rx_word[lane];
      else if (h_addr == A_ICR)  h_rdata = icr_rd;
      else if (h_addr == A_STAT) h_rdata[1:0] = {txe, rxf};
      else if (data_hit)         h_rdata = rx_word[host_lane];
   end

   assign p_h2p_data  = tx_word;
   assign p_h2p_valid = ~txe;
   assign p_p2h_ready = ~rxf;

endmodule

// File: rtl/hpi_host_port_chk.sv
`timescale 1ns/1ps
module hpi_host_port_chk #(
   parameter int ADDR_W    = 3,
   parameter int ICR_ADDR  = 0,
   parameter int DATA_BASE = 5,
   parameter int BYTE_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_wr,
   input logic              h_rd,
   input logic              h_ack,
   input logic [BYTE_W-1:0] h_rdata,
   input logic [2:0]        p_mode,
   input logic              hf_status,
   input logic              host_req,
   input logic              p_h2p_valid,
   input logic              p_h2p_take,
   input logic              p_p2h_ready,
   input logic              dma_on,
   input logic              treq_en,
   input logic              rreq_en
);

   localparam logic [ADDR_W-1:0] A_ICR  = ADDR_W'(ICR_ADDR);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(DATA_BASE + 2);

   // R2
   flag_host_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_wr && h_addr == A_ICR) |=> $stable(hf_status));

   // R3
   shared_bit6_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_mode != 3'b100 && h_addr == A_ICR && !h_ack) |-> !h_rdata[6]);

   // R6
   h2p_word_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(p_h2p_valid) |-> $past((h_wr && h_addr == A_LAST) || h_ack));

   // R6
   p2h_empty_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(p_p2h_ready) |-> $past((h_rd && h_addr == A_LAST) || h_ack));

   // R8
   dma_dir_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_on && treq_en && rreq_en) |-> !host_req);

   // R11
   h2p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_h2p_valid && !p_h2p_take) |=> p_h2p_valid);

endmodule

bind hpi_host_port hpi_host_port_chk #(
   .ADDR_W(ADDR_W), .ICR_ADDR(ICR_ADDR), .DATA_BASE(DATA_BASE), .BYTE_W(BYTE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
   .h_ack(h_ack), .h_rdata(h_rdata), .p_mode(p_mode), .hf_status(hf_status),
   .host_req(host_req), .p_h2p_valid(p_h2p_valid), .p_h2p_take(p_h2p_take),
   .p_p2h_ready(p_p2h_ready), .dma_on(dma_on), .treq_en(treq_en), .rreq_en(rreq_en)
);

// File: tb/tb_hpi_host_port.sv
`timescale 1ns/1ps
module tb_hpi_host_port;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  h_addr;
   logic        h_wr, h_rd, h_ack;
   logic [7:0]  h_wdata, h_rdata;
   logic        host_req;
   logic [2:0]  p_mode;
   logic        hf_status;
   logic [23:0] p_h2p_data, p_p2h_data;
   logic        p_h2p_valid, p_h2p_take, p_p2h_load, p_p2h_ready;

   int vecs  = 0;
   int fails = 0;

   always #(CLK_P/2) clk = ~clk;

   hpi_host_port dut (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .host_req(host_req),
      .p_mode(p_mode), .hf_status(hf_status), .p_h2p_data(p_h2p_data),
      .p_h2p_valid(p_h2p_valid), .p_h2p_take(p_h2p_take), .p_p2h_data(p_p2h_data),
      .p_p2h_load(p_p2h_load), .p_p2h_ready(p_p2h_ready)
   );

   // ---------------- reference functions ----------------
   function automatic int lane_of(logic [2:0] a, bit little);
      return little ? (int'(a) - 5) : (7 - int'(a));
   endfunction

   function automatic int nbytes(logic [1:0] m);
      return (m == 2'b01) ? 3 : (m == 2'b10) ? 2 : 1;
   endfunction

   // ---------------- check and drive tasks ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(negedge clk); h_wr = 1'b0; #1;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); h_addr = a; h_rd = 1'b1; #1 d = h_rdata;
      @(negedge clk); h_rd = 1'b0; #1;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); h_addr = a; h_rd = 1'b0; #1 d = h_rdata;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk); p_mode = m; #1;
   endtask

   task automatic take();
      @(negedge clk); p_h2p_take = 1'b1;
      @(negedge clk); p_h2p_take = 1'b0; #1;
   endtask

   task automatic load(input logic [23:0] w);
      @(negedge clk); p_p2h_data = w; p_p2h_load = 1'b1;
      @(negedge clk); p_p2h_load = 1'b0; #1;
   endtask

   task automatic ack_cycle(input logic [7:0] wb, output logic [7:0] rb);
      @(negedge clk); h_addr = 3'd1; h_wdata = wb; h_ack = 1'b1; #1 rb = h_rdata;
      @(negedge clk); h_ack = 1'b0; #1;
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      logic [7:0]  rb, dummy;
      logic [23:0] w, expw;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; h_addr = '0; h_wr = 0; h_rd = 0; h_ack = 0; h_wdata = '0;
      p_mode = 3'b000; p_h2p_take = 0; p_p2h_data = '0; p_p2h_load = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;

      // R1 reset state
      peek(3'd0, rb); chk("R1 ctrl", rb, 8'h00);
      peek(3'd2, rb); chk("R1 status", rb, 8'h02);
      chk("R1 req", host_req, 1'b0);
      chk("R1 flag", hf_status, 1'b0);

      // R2/R3 control register access across modes
      hwr(3'd0, 8'hFF);
      peek(3'd0, rb); chk("R2 R3 mode000 readback", rb, 8'h33);
      chk("R2 flag mirrored", hf_status, 1'b1);
      set_mode(3'b100);
      peek(3'd0, rb); chk("R3 mode100 bit6 untouched", rb, 8'h33);
      hwr(3'd0, 8'h73);
      peek(3'd0, rb); chk("R3 mode100 bit6 stored", rb, 8'h73);
      set_mode(3'b010);
      peek(3'd0, rb); chk("R3 mode010 hides 6:5", rb, 8'h13);
      hwr(3'd0, 8'h10);
      set_mode(3'b100);
      peek(3'd0, rb); chk("R3 ignored writes keep 6:5", rb, 8'h70);
      load(24'hABCDEF); take(); set_mode(3'b001);
      chk("R2 flag unaffected by processor", hf_status, 1'b1);
      hrd(3'd7, dummy);
      hwr(3'd0, 8'h00);
      chk("R2 flag cleared by host", hf_status, 1'b0);

      // R5 little-endian ignored outside mode 000
      set_mode(3'b000); hwr(3'd0, 8'h20); set_mode(3'b010);
      load(24'h112233);
      peek(3'd5, rb); chk("R5 bit5 inert in mode010", rb, 8'h11);
      hrd(3'd7, dummy);

      // R7 interrupt request and inert acknowledge
      set_mode(3'b000); hwr(3'd0, 8'h02);
      chk("R7 tx request", host_req, 1'b1);
      hwr(3'd0, 8'h01);
      chk("R7 rx request idle", host_req, 1'b0);
      load(24'hC0FFEE);
      chk("R7 rx request", host_req, 1'b1);
      ack_cycle(8'h55, rb);
      chk("R7 ack inert ready", p_p2h_ready, 1'b0);
      chk("R7 ack inert valid", p_h2p_valid, 1'b0);
      hrd(3'd7, rb); chk("R4 low byte at 7", rb, 8'hEE);
      chk("R6 read 7 empties", p_p2h_ready, 1'b1);
      chk("R7 request drops", host_req, 1'b0);

      // R4/R5/R6/R11 random interrupt-mode traffic
      for (int it = 0; it < 24; it++) begin
         automatic bit little = $urandom_range(0, 1);
         automatic logic [7:0] b5 = 8'($urandom), b6 = 8'($urandom), b7 = 8'($urandom);
         hwr(3'd0, little ? 8'h20 : 8'h00);
         expw = '0;
         expw[8*lane_of(3'd5, little) +: 8] = b5;
         expw[8*lane_of(3'd6, little) +: 8] = b6;
         expw[8*lane_of(3'd7, little) +: 8] = b7;
         if ($urandom_range(0, 1)) begin hwr(3'd5, b5); hwr(3'd6, b6); end
         else begin hwr(3'd6, b6); hwr(3'd5, b5); end
         chk("R6 no word before 7", p_h2p_valid, 1'b0);
         hwr(3'd7, b7);
         chk("R6 word valid", p_h2p_valid, 1'b1);
         chk(little ? "R5 h2p word" : "R4 h2p word", p_h2p_data, expw);
         take();
         chk("R11 take empties", p_h2p_valid, 1'b0);
         w = 24'($urandom);
         load(w);
         chk("R11 load fills", p_p2h_ready, 1'b0);
         peek(3'd5, rb); chk(little ? "R5 rd5" : "R4 rd5", rb, w[8*lane_of(3'd5, little) +: 8]);
         peek(3'd6, rb); chk(little ? "R5 rd6" : "R4 rd6", rb, w[8*lane_of(3'd6, little) +: 8]);
         hrd(3'd7, rb);  chk(little ? "R5 rd7" : "R4 rd7", rb, w[8*lane_of(3'd7, little) +: 8]);
         chk("R6 read empties", p_p2h_ready, 1'b1);
      end

      // R8 both directions selected
      set_mode(3'b100); hwr(3'd0, 8'h23);
      chk("R8 both dirs no request", host_req, 1'b0);
      hwr(3'd0, 8'h20);
      chk("R8 no dir no request", host_req, 1'b0);

      // R8/R9/R10 random DMA traffic
      for (int it = 0; it < 30; it++) begin
         automatic logic [1:0] m = 2'($urandom_range(1, 3));
         automatic bit h2p = $urandom_range(0, 1);
         automatic int n = nbytes(m);
         hwr(3'd0, {1'b0, m, 3'b000, h2p, ~h2p});
         if (h2p) begin
            expw = '0;
            for (int k = 0; k < n; k++) begin
               automatic logic [7:0] b = 8'($urandom);
               chk("R8 h2p request", host_req, 1'b1);
               expw[8*k +: 8] = b;
               ack_cycle(b, rb);
               if (k < n - 1) chk("R9 no early word", p_h2p_valid, 1'b0);
            end
            chk("R9 word valid", p_h2p_valid, 1'b1);
            chk("R9 word data", p_h2p_data, expw);
            chk("R9 request drops", host_req, 1'b0);
            take();
            chk("R8 request back", host_req, 1'b1);
         end else begin
            chk("R8 p2h idle", host_req, 1'b0);
            w = 24'($urandom);
            load(w);
            for (int k = 0; k < n; k++) begin
               chk("R8 p2h request", host_req, 1'b1);
               ack_cycle(8'h00, rb);
               chk("R10 lane byte", rb, w[8*k +: 8]);
            end
            chk("R10 emptied", p_p2h_ready, 1'b1);
            chk("R10 request drops", host_req, 1'b0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule